// File: doc/BRIEF.md
# Double-Buffered SPI Slave Port

This block is an SPI slave with a small register port for a local processor. One data address serves both directions: a write puts a byte into a transmit holding buffer, and a read returns the last byte received. A second address gives status flags on read and interrupt enables on write. The holding buffer lets the processor queue the next outgoing byte while the current one is still shifting, so consecutive transfers need no tight software timing.

The serial pins (`sck`, `mosi`, `ss_n`) are asynchronous to `clk` and pass through two-flop synchronizers, so `clk` must run at least four times faster than `sck`. The serial timing is fixed: `sck` idles low, the slave launches `miso` on each rising edge and captures `mosi` on each falling edge, most significant bit first. A single interrupt output combines the two flags through their enables.

Top module: `spi_slave_dbuf`

## Requirements
- R1: After reset the status reads 0x20 (only the transmit-empty flag, status bit 5, set), `irq` is 0 and `miso_oe` is 0.
- R2: A write with `cpu_addr`=0 loads the transmit buffer and clears transmit-empty (status bit 5).
- R3: On the first rising `sck` edge of a byte, a queued buffer moves into the shift register and transmit-empty sets, so a byte written during a transfer is sent in the next one.
- R4: If nothing is written before a transfer starts, the slave sends the shift register's content, which equals the byte it last received.
- R5: Bytes move most significant bit first; `miso` changes after rising `sck` and `mosi` is captured on falling `sck`. After the eighth falling edge the received byte is readable at `cpu_addr`=0 and receive-full (status bit 7) sets.
- R6: Receive-full clears only when a status read made while it is set is followed by a data read; a data read alone leaves it set.
- R7: A byte that completes while receive-full is set sets overflow (status bit 6) and is dropped; the status-then-data read sequence clears overflow too.
- R8: While `ss_n` is high `miso_oe` is 0; raising `ss_n` mid-byte discards the partial byte, does not set receive-full, and the next byte starts aligned at bit 7.
- R9: `irq` = (transmit-empty AND transmit enable) OR (receive-full AND receive enable); the enables are bits 0 and 1 written at `cpu_addr`=1 and read back at the same status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | 1 | Register access strobe, one cycle per access |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 1 | 0 = data, 1 = status/control |
| cpu_wdata | input | W | Write data |
| cpu_rdata | output | W | Read data (combinational from address) |
| sck | input | 1 | Serial clock from master, idles low |
| mosi | input | 1 | Serial data from master |
| ss_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for the external `miso` driver |
| irq | output | 1 | Combined interrupt request |

## Verification
The main path runs through all 256 transmit values, each with a different master-side byte computed from it, so a bit-order reversal, an off-by-one shift or a dropped edge shows up as a mismatch on both directions at once. Separate patterns cover a byte queued mid-transfer (tells holding-buffer timing apart from direct shift-register writes), a transfer with no new write (shows the in-place resend), two unread bytes (overflow with the first byte kept), a data read without a prior status read, and a select abort after three bits followed by a clean byte (shows the bit counter resets).

// File: rtl/spi_slave_dbuf.sv
module spi_slave_dbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_sel,
  input  logic         cpu_wr,
  input  logic         cpu_addr,
  input  logic [W-1:0] cpu_wdata,
  output logic [W-1:0] cpu_rdata,
  input  logic         sck,
  input  logic         mosi,
  input  logic         ss_n,
  output logic         miso,
  output logic         miso_oe,
  output logic         irq
);
  localparam int CW = $clog2(W);

  logic [2:0]    sck_s;
  logic [1:0]    mosi_s, ss_s;
  logic [W-1:0]  txbuf, shreg, rxbuf;
  logic [CW-1:0] bitcnt;
  logic          tx_empty, rx_full, ovf, armed, tx_ie, rx_ie, miso_q;

  wire          active   = ~ss_s[1];
  wire          sck_rise = active & sck_s[1] & ~sck_s[2];
  wire          sck_fall = active & ~sck_s[1] & sck_s[2];
  wire          last     = bitcnt == CW'(W - 1);
  wire [W-1:0]  shifted  = {shreg[W-2:0], mosi_s[1]};
  wire          wr_data  = cpu_sel & cpu_wr & ~cpu_addr;
  wire          wr_ctl   = cpu_sel & cpu_wr & cpu_addr;
  wire          rd_data  = cpu_sel & ~cpu_wr & ~cpu_addr;
  wire          rd_stat  = cpu_sel & ~cpu_wr & cpu_addr;
  wire          clr_rx   = rd_data & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s    <= '0;
      mosi_s   <= '0;
      ss_s     <= '1;
      txbuf    <= '0;
      shreg    <= '0;
      rxbuf    <= '0;
      bitcnt   <= '0;
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      ovf      <= 1'b0;
      armed    <= 1'b0;
      tx_ie    <= 1'b0;
      rx_ie    <= 1'b0;
      miso_q   <= 1'b0;
    end else begin
      sck_s  <= {sck_s[1:0], sck};
      mosi_s <= {mosi_s[0], mosi};
      ss_s   <= {ss_s[0], ss_n};

      if (!active) bitcnt <= '0;
      else if (sck_fall) begin
        shreg  <= shifted;
        bitcnt <= last ? '0 : bitcnt + 1'b1;
      end

      if (sck_rise) begin
        if (bitcnt == '0) begin
          tx_empty <= 1'b1;
          if (!tx_empty) begin
            shreg  <= txbuf;
            miso_q <= txbuf[W-1];
          end else miso_q <= shreg[W-1];
        end else miso_q <= shreg[W-1];
      end

      if (rd_stat && rx_full) armed <= 1'b1;
      if (clr_rx) begin
        rx_full <= 1'b0;
        ovf     <= 1'b0;
        armed   <= 1'b0;
      end

      if (sck_fall && last) begin
        if (rx_full && !clr_rx) ovf <= 1'b1;
        else begin
          rxbuf   <= shifted;
          rx_full <= 1'b1;
        end
      end

      if (wr_data) begin
        txbuf    <= cpu_wdata;
        tx_empty <= 1'b0;
      end
      if (wr_ctl) {rx_ie, tx_ie} <= cpu_wdata[1:0];
    end
  end

  assign cpu_rdata = cpu_addr ? W'({rx_full, ovf, tx_empty, 3'b000, rx_ie, tx_ie}) : rxbuf;
  assign miso      = miso_q;
  assign miso_oe   = active;
  assign irq       = (tx_empty & tx_ie) | (rx_full & rx_ie);
endmodule

module spi_slave_dbuf_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_data,
  input logic         rd_data,
  input logic         clr_rx,
  input logic         tx_empty,
  input logic         rx_full,
  input logic         ovf,
  input logic [W-1:0] rxbuf,
  input logic         ss_n,
  input logic         miso_oe
);
  p_wr_clears_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> !tx_empty);

  p_rx_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_full) && rx_full && !$past(clr_rx)) |-> $stable(rxbuf));

  p_full_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(rd_data));

  p_ovf_only_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> rx_full);

  p_no_drive_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $past(ss_n) && $past(ss_n, 2)) |-> !miso_oe);
endmodule

bind spi_slave_dbuf spi_slave_dbuf_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .rd_data(rd_data), .clr_rx(clr_rx),
  .tx_empty(tx_empty), .rx_full(rx_full), .ovf(ovf), .rxbuf(rxbuf),
  .ss_n(ss_n), .miso_oe(miso_oe)
);

// File: tb/test_spi_slave_dbuf.sv
module test_spi_slave_dbuf;
  localparam int HALF = 6;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_addr = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic       miso, miso_oe, irq;
  int         tests = 0, fails = 0;
  logic [7:0] got, rd;

  always #2 clk = ~clk;

  spi_slave_dbuf #(.W(8)) i_spi_slave_dbuf (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sck(sck), .mosi(mosi), .ss_n(ss_n),
    .miso(miso), .miso_oe(miso_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic a, input logic [7:0] d);
    @(negedge clk); cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic cpu_read(input logic a, output logic [7:0] d);
    @(negedge clk); cpu_sel = 1; cpu_wr = 0; cpu_addr = a; #1 d = cpu_rdata;
    @(negedge clk); cpu_sel = 0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // master transfer of nbits; optionally queue a byte after the first rising edge
  task automatic xfer(input logic [7:0] mo, input int nbits, input bit q,
                      input logic [7:0] qv, output logic [7:0] mi);
    logic [7:0] s;
    mi = '0;
    @(negedge clk); ss_n = 0;
    wait_clk(HALF);
    for (int i = 7; i > 7 - nbits; i--) begin
      sck = 1; mosi = mo[i];
      wait_clk(HALF);
      if (q && i == 7) begin
        cpu_read(1'b1, s);
        chk("R3 empty sets at start", s & 8'h20, 8'h20);
        cpu_write(1'b0, qv);
      end
      mi[i] = miso;
      sck = 0;
      wait_clk(HALF);
    end
    ss_n = 1;
    wait_clk(HALF);
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] m, m2;
    wait_clk(4); rst_n = 1; wait_clk(2);

    cpu_read(1'b1, rd);
    chk("R1 status", rd, 8'h20);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 oe", {7'b0, miso_oe}, 8'h00);

    for (int v = 0; v < 256; v++) begin
      m = 8'((v * 37 + 11) ^ 8'h5A);
      cpu_write(1'b0, 8'(v));
      cpu_read(1'b1, rd);
      chk("R2 empty clears", rd & 8'h20, 8'h00);
      xfer(m, 8, 0, 0, got);
      chk("R5 miso byte", got, 8'(v));
      cpu_read(1'b1, rd);
      chk("R5 full set", rd & 8'hE0, 8'hA0);
      cpu_read(1'b0, rd);
      chk("R5 rx byte", rd, m);
      cpu_read(1'b1, rd);
      chk("R6 full cleared", rd & 8'h80, 8'h00);
    end

    cpu_write(1'b0, 8'h3C);
    xfer(8'hC1, 8, 1, 8'h96, got);
    chk("R3 first byte", got, 8'h3C);
    cpu_read(1'b1, rd); cpu_read(1'b0, rd);
    chk("R5 rx C1", rd, 8'hC1);
    xfer(8'h0F, 8, 0, 0, got);
    chk("R3 queued byte sent", got, 8'h96);
    cpu_read(1'b1, rd); cpu_read(1'b0, rd);

    xfer(8'h71, 8, 0, 0, got);
    chk("R4 resend received", got, 8'h0F);
    cpu_read(1'b0, rd);
    cpu_read(1'b1, rd);
    chk("R6 data read alone keeps full", rd & 8'h80, 8'h80);
    cpu_read(1'b0, rd);
    chk("R6 data", rd, 8'h71);
    cpu_read(1'b1, rd);
    chk("R6 cleared", rd & 8'h80, 8'h00);

    xfer(8'hE4, 8, 0, 0, got);
    xfer(8'h2B, 8, 0, 0, got);
    cpu_read(1'b1, rd);
    chk("R7 ovf and full", rd & 8'hC0, 8'hC0);
    cpu_read(1'b0, rd);
    chk("R7 first kept", rd, 8'hE4);
    cpu_read(1'b1, rd);
    chk("R7 flags cleared", rd & 8'hC0, 8'h00);

    cpu_write(1'b0, 8'hB7);
    chk("R8 oe off", {7'b0, miso_oe}, 8'h00);
    xfer(8'hFF, 3, 0, 0, got);
    cpu_read(1'b1, rd);
    chk("R8 partial no full", rd & 8'h80, 8'h00);
    cpu_write(1'b0, 8'h5D);
    xfer(8'h84, 8, 0, 0, got);
    chk("R8 aligned miso", got, 8'h5D);
    cpu_read(1'b1, rd); cpu_read(1'b0, rd);
    chk("R8 aligned rx", rd, 8'h84);

    cpu_write(1'b1, 8'h01);
    cpu_read(1'b1, rd);
    chk("R9 tx irq", {rd[1:0], 5'b0, irq}, 8'h41);
    cpu_write(1'b0, 8'h11);
    chk("R9 tx irq off after write", {7'b0, irq}, 8'h00);
    cpu_write(1'b1, 8'h02);
    xfer(8'h22, 8, 0, 0, got);
    chk("R9 rx irq", {7'b0, irq}, 8'h01);
    cpu_read(1'b1, rd); cpu_read(1'b0, rd);
    chk("R9 rx irq cleared", {7'b0, irq}, 8'h00);
    m2 = rd;
    chk("R9 rx data", m2, 8'h22);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule